// File: doc/BRIEF.md
# Shadowed Seconds Real-Time Clock

This block is a real-time clock on a small memory-mapped register bus. It takes a slow tick enable, derived elsewhere from a 32 kHz reference. From that tick it counts milliseconds and a 32-bit seconds value. Software does not see the live counters. It sees a bus-side copy, which is refreshed once per group of ticks. A busy flag is raised for a short window before each refresh, and the copy lands as that window closes.

Reading the milliseconds register latches the bus-side seconds value into a shadow register on the same edge. A following read of the shadow therefore returns the seconds that belong to the milliseconds just read.

Two interrupt sources share one status/mask pair and drive a level-high interrupt line:
- a seconds-match alarm, which a compare value of zero turns off;
- a countdown that fires every N seconds from a reload value.

Software writes the seconds register to set the time. If that write arrives during the busy window, it is held and applied when the window ends.

Top module: `rtc_shadow_timer`

## Requirements
- R1: After reset, every readable register reads 0 and `irq` is low.
- R2: One copy is made for every COPY_TICKS ticks. After the tick that completes a group, bit 0 of the busy register (offset 0x004) reads 1 for BUSY_CYCLES clock cycles. The seconds (0x008) and milliseconds (0x010) registers keep their old values during that window and show the live values once it ends.
- R3: TICKS_PER_MS ticks make one millisecond. Milliseconds count from 0 to MS_PER_SEC-1, then return to 0 and advance the seconds. Seconds wrap from 0xFFFFFFFF to 0.
- R4: A bus read of milliseconds copies the bus-side seconds into the shadow register (0x00C) on that edge. On the edge where a copy also lands, the shadow takes the seconds that were current at the read.
- R5: The alarm compare register (0x014) is off when it holds 0. When it is nonzero, status bit 0 is set on the edge where the seconds advance to that value.
- R6: A nonzero reload value written to 0x020 sets status bit 1 once every N seconds, counting from the write. A reload of 0 stops the countdown.
- R7: Writing the status register (0x018) clears each status bit that is 1 in the written data. A source event on the same edge as the clear leaves its bit set.
- R8: `irq` is the OR of status AND mask. The mask register is at 0x01C, with bit 0 for the alarm and bit 1 for the countdown. Writing 0 to the mask drops `irq`.
- R9: A seconds write outside the busy window takes effect on the next edge and clears milliseconds to 0. A seconds write during the busy window is held and applied at the edge that ends the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle pulse per slow reference tick |
| addr | input | 8 | Register byte offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; a read of milliseconds latches the shadow |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Level-high interrupt |

## Verification
Three pairs of events can land on the same edge, and each pair is tested.

The first pair is the last busy cycle and a milliseconds read. The bench reads milliseconds in that cycle and then reads the shadow. Both must return the old pair, not the newly copied seconds.

The second pair is a status clear and an alarm match. The bench drives a tick that advances the seconds onto the alarm value together with a status write that clears bit 0. The bit must still read 1 afterwards.

The third pair is a seconds write issued inside the busy window. It must stay invisible until the window ends, and then it must override that window's copy.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_BUSY   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SEC    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SHADOW = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MS     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_ALARM  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 8'h20;
  localparam int NUM_SRC = 2;  // bit 0 alarm, bit 1 countdown

  typedef struct packed {
    logic secLoad;
    logic copyNow;
    logic msRead;
    logic alarmWr;
    logic reloadWr;
    logic statusWr;
    logic maskWr;
  } strobe_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int COPY_TICKS  = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [31:0]       wdata,
  output logic              busy,
  output strobe_t           strobes,
  output logic [31:0]       loadData
);
  localparam int CW = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] copyCnt;
  logic [BW-1:0] busyCnt;
  logic          pendValid;
  logic [31:0]   pendData;
  logic          copyStart, lastBusy, wrSec;

  assign copyStart = tickIn && (copyCnt == CW'(COPY_TICKS - 1));
  assign busy      = (busyCnt != '0);
  assign lastBusy  = (busyCnt == BW'(1));
  assign wrSec     = wrEn && (addr == OFS_SEC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      copyCnt   <= '0;
      busyCnt   <= '0;
      pendValid <= 1'b0;
      pendData  <= '0;
    end else begin
      if (tickIn) copyCnt <= copyStart ? '0 : copyCnt + 1'b1;
      if (copyStart)  busyCnt <= BW'(BUSY_CYCLES);
      else if (busy)  busyCnt <= busyCnt - 1'b1;
      if (lastBusy) pendValid <= 1'b0;
      else if (wrSec && busy) begin
        pendValid <= 1'b1;
        pendData  <= wdata;
      end
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.secLoad  = (wrSec && !busy) || (lastBusy && (pendValid || wrSec));
    strobes.copyNow  = lastBusy;
    strobes.msRead   = rdEn && (addr == OFS_MS);
    strobes.alarmWr  = wrEn && (addr == OFS_ALARM);
    strobes.reloadWr = wrEn && (addr == OFS_RELOAD);
    strobes.statusWr = wrEn && (addr == OFS_STATUS);
    strobes.maskWr   = wrEn && (addr == OFS_MASK);
    loadData         = wrSec ? wdata : pendData;
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_MS = 32,
  parameter int MS_PER_SEC   = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  strobe_t           strobes,
  input  logic [31:0]       loadData,
  input  logic [31:0]       wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int TW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam int MW = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;

  logic [TW-1:0]      tickCnt;
  logic [MW-1:0]      msLive, msVis;
  logic [31:0]        secLive, secVis, shadowSec, alarmSec, reloadVal, cdCnt;
  logic [NUM_SRC-1:0] status, mask, srcHit, clrBits;
  logic               msStep, secStep, secAdv;
  logic [31:0]        secNext;

  assign msStep  = tickIn && (tickCnt == TW'(TICKS_PER_MS - 1));
  assign secStep = msStep && (msLive == MW'(MS_PER_SEC - 1));
  assign secAdv  = secStep && !strobes.secLoad;
  assign secNext = secLive + 32'd1;

  assign srcHit[0] = secAdv && (alarmSec != '0) && (secNext == alarmSec);
  assign srcHit[1] = secAdv && !strobes.reloadWr && (reloadVal != '0) && (cdCnt <= 32'd1);
  assign clrBits   = strobes.statusWr ? wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;  msLive <= '0;  secLive <= '0;
      secVis  <= '0;  msVis  <= '0;  shadowSec <= '0;
      alarmSec <= '0; reloadVal <= '0; cdCnt <= '0;
      status  <= '0;  mask   <= '0;
    end else begin
      // live counters
      if (strobes.secLoad) begin
        secLive <= loadData;
        msLive  <= '0;
        tickCnt <= '0;
      end else if (tickIn) begin
        tickCnt <= msStep ? '0 : tickCnt + 1'b1;
        if (msStep)  msLive  <= secStep ? '0 : msLive + 1'b1;
        if (secStep) secLive <= secNext;
      end
      // bus-side copy
      if (strobes.secLoad) begin
        secVis <= loadData;
        msVis  <= '0;
      end else if (strobes.copyNow) begin
        secVis <= secLive;
        msVis  <= msLive;
      end
      if (strobes.msRead)  shadowSec <= secVis;
      if (strobes.alarmWr) alarmSec  <= wdata;
      // countdown
      if (strobes.reloadWr) begin
        reloadVal <= wdata;
        cdCnt     <= wdata;
      end else if (secAdv && reloadVal != '0) begin
        cdCnt <= (cdCnt <= 32'd1) ? reloadVal : cdCnt - 32'd1;
      end
      status <= (status & ~clrBits) | srcHit;
      if (strobes.maskWr) mask <= wdata[NUM_SRC-1:0];
    end
  end

  assign irq = |(status & mask);

  always_comb begin
    case (addr)
      OFS_BUSY:   rdata = {31'd0, busy};
      OFS_SEC:    rdata = secVis;
      OFS_SHADOW: rdata = shadowSec;
      OFS_MS:     rdata = 32'(msVis);
      OFS_ALARM:  rdata = alarmSec;
      OFS_STATUS: rdata = 32'(status);
      OFS_MASK:   rdata = 32'(mask);
      OFS_RELOAD: rdata = reloadVal;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_shadow_timer.sv
module rtc_shadow_timer
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_MS = 32,
  parameter int MS_PER_SEC   = 1000,
  parameter int COPY_TICKS   = 8,
  parameter int BUSY_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic [7:0]  addr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  logic        busy;
  strobe_t     strobes;
  logic [31:0] loadData;

  rtc_ctrl #(.COPY_TICKS(COPY_TICKS), .BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wdata(wdata), .busy(busy), .strobes(strobes),
    .loadData(loadData)
  );

  rtc_datapath #(.TICKS_PER_MS(TICKS_PER_MS), .MS_PER_SEC(MS_PER_SEC)) uPath (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .strobes(strobes),
    .loadData(loadData), .wdata(wdata), .addr(addr), .busy(busy),
    .rdata(rdata), .irq(irq)
  );
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        tickIn,
  input logic [7:0]  addr,
  input logic        wrEn,
  input logic [31:0] wdata,
  input logic        irq,
  input logic        busy,
  input logic        secLoad,
  input logic        copyNow
);
  AST_BUSY_FROM_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(tickIn)); // R2
  AST_COPY_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    copyNow |=> !busy); // R2
  AST_HELD_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (secLoad && busy) |=> !busy); // R9
  AST_CLEAR_ALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_STATUS && wdata[1:0] == 2'b11 && !tickIn) |=> !irq); // R7
  AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_MASK && wdata[1:0] == 2'b00) |=> !irq); // R8
endmodule

bind rtc_shadow_timer rtc_checker uChk (
  .clk(clk), .rstN(rstN), .tickIn(tickIn), .addr(addr), .wrEn(wrEn),
  .wdata(wdata), .irq(irq), .busy(busy), .secLoad(strobes.secLoad),
  .copyNow(strobes.copyNow)
);

// File: tb/tb_rtc_shadow_timer.sv
module tb_rtc_shadow_timer;
  localparam logic [7:0] A_BUSY = 8'h04, A_SEC = 8'h08, A_SHD = 8'h0C, A_MS = 8'h10;
  localparam logic [7:0] A_ALM = 8'h14, A_STS = 8'h18, A_MSK = 8'h1C, A_RLD = 8'h20;

  logic clk = 1'b0, rstN = 1'b0, tickIn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic probe = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  // 1 ms = 2 ticks, 1 s = 5 ms = 10 ticks, copy every 8 ticks, busy 3 cycles
  rtc_shadow_timer #(.TICKS_PER_MS(2), .MS_PER_SEC(5), .COPY_TICKS(8), .BUSY_CYCLES(3)) dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  // monitor: pops expected items as results appear
  always begin
    @(negedge clk);
    #4;
    if (rdEn || probe) begin
      logic [31:0] act, exp;
      string tag;
      act = probe ? {31'd0, irq} : rdata;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
    end
  end

  task automatic idleDefaults();
    tickIn = 1'b0; wrEn = 1'b0; rdEn = 1'b0; probe = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idleDefaults();
    end
  endtask

  task automatic tickOnce();
    @(negedge clk);
    idleDefaults();
    tickIn = 1'b1;
  endtask

  task automatic tickN(input int n);
    for (int i = 0; i < n; i++) begin
      tickOnce();
      idle(9);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    idleDefaults();
    wrEn = 1'b1; addr = a; wdata = d;
  endtask

  task automatic tickWithWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    idleDefaults();
    tickIn = 1'b1; wrEn = 1'b1; addr = a; wdata = d;
  endtask

  task automatic readChk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    idleDefaults();
    rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(tag);
  endtask

  task automatic irqChk(input logic e, input string tag);
    @(negedge clk);
    idleDefaults();
    probe = 1'b1;
    expQ.push_back({31'd0, e}); tagQ.push_back(tag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    readChk(A_BUSY, 0, "R1 busy");
    readChk(A_SEC, 0, "R1 sec");
    readChk(A_MS, 0, "R1 ms");
    readChk(A_SHD, 0, "R1 shadow");
    readChk(A_STS, 0, "R1 status");
    irqChk(1'b0, "R1 irq");
    // R2: no copy before the 8th tick
    tickN(7);
    readChk(A_MS, 0, "R2 ms before copy");
    tickOnce();                                   // tick 8: 4 ms live
    readChk(A_BUSY, 1, "R2 busy 1st");
    readChk(A_BUSY, 1, "R2 busy 2nd");
    readChk(A_MS, 0, "R2 ms held in window");
    readChk(A_BUSY, 0, "R2 busy ends");
    readChk(A_MS, 4, "R3 ms after copy");
    idle(5);
    // R4: ms read on the copy edge; tick 16 -> 1 s 3 ms
    tickN(7);
    tickOnce();
    readChk(A_BUSY, 1, "R2 busy");
    readChk(A_SEC, 0, "R2 sec held");
    readChk(A_MS, 4, "R4 ms on copy edge");
    readChk(A_SHD, 0, "R4 shadow old pair");
    readChk(A_SEC, 1, "R3 sec advance");
    readChk(A_MS, 3, "R3 ms wrap");
    readChk(A_SHD, 1, "R4 shadow new pair");
    idle(5);
    // R9: write during busy (tick 24)
    tickN(7);
    tickOnce();
    writeReg(A_SEC, 32'd100);
    readChk(A_SEC, 1, "R9 held write invisible");
    readChk(A_BUSY, 1, "R9 window still open");
    readChk(A_SEC, 100, "R9 held write applied");
    readChk(A_MS, 0, "R9 ms cleared");
    // R9: immediate write outside busy
    writeReg(A_SEC, 32'd200);
    readChk(A_SEC, 200, "R9 immediate write");
    readChk(A_MS, 0, "R9 immediate ms clear");
    tickN(10);                                    // copy at 8 ticks after load
    readChk(A_SEC, 200, "R3 sec after load");
    readChk(A_MS, 4, "R3 ms after load");
    tickN(6);                                     // copy at 16 ticks: 8 ms
    readChk(A_SEC, 201, "R3 sec after load 2");
    readChk(A_MS, 3, "R3 ms after load 2");
    // R3 wrap and R5 disabled alarm
    writeReg(A_MSK, 32'd3);
    writeReg(A_ALM, 32'd0);
    writeReg(A_SEC, 32'hFFFF_FFFF);
    tickN(10);                                    // seconds wrap to 0
    readChk(A_STS, 0, "R5 zero alarm no match at 0");
    irqChk(1'b0, "R5 irq quiet");
    tickN(6);
    readChk(A_SEC, 0, "R3 32-bit wrap");
    readChk(A_MS, 3, "R3 ms after wrap");
    // R5 alarm at second 1 (live 8 ms)
    writeReg(A_ALM, 32'd1);
    tickN(3);
    readChk(A_STS, 0, "R5 before match");
    tickN(1);
    readChk(A_STS, 1, "R5 alarm set");
    irqChk(1'b1, "R8 irq alarm");
    // R7 clear
    writeReg(A_STS, 32'd1);
    irqChk(1'b0, "R7 irq after clear");
    readChk(A_STS, 0, "R7 status cleared");
    // R6 countdown reload 2, mask 0
    writeReg(A_MSK, 32'd0);
    writeReg(A_RLD, 32'd2);
    tickN(10);
    readChk(A_STS, 0, "R6 one second not yet");
    tickN(10);
    readChk(A_STS, 2, "R6 countdown fired");
    irqChk(1'b0, "R8 masked source");
    writeReg(A_MSK, 32'd2);
    irqChk(1'b1, "R8 mask enables");
    writeReg(A_MSK, 32'd0);
    irqChk(1'b0, "R8 zero mask");
    writeReg(A_STS, 32'hFFFF_FFFF);
    readChk(A_STS, 0, "R7 clear all");
    // R7 set beats clear: seconds reach 4 on the same edge as clear of bit 0
    writeReg(A_ALM, 32'd4);
    tickN(9);
    tickWithWrite(A_STS, 32'd1);
    idle(9);
    readChk(A_STS, 1, "R7 set wins over clear");
    // R6 reload 0 disables
    writeReg(A_RLD, 32'd0);
    writeReg(A_STS, 32'd3);
    tickN(20);
    readChk(A_STS, 0, "R6 zero reload quiet");
    idle(3);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule